// File: doc/BRIEF.md
# Paged I2C Command Sequencer for a Display Data Channel

This block is an I2C bus master driven entirely through four 32-bit registers. Software picks one bus primitive at a time: start condition, page write, page read that acknowledges every byte, page read that leaves the last byte unacknowledged, or stop condition. It also sets a page length of one to eight bytes and then sets a trigger bit. The block carries out that single primitive on the clock and data lines and clears the trigger by itself when the primitive is over. While the trigger reads 1, the bus is busy.

Page bytes live in two data words, with the lowest byte first. A write page shifts them out most significant bit first. A read page stores each received byte at the same position it would have been taken from. An eight-bit acknowledge vector records the acknowledge slot of every byte of the page. Software builds whole transfers from a chain of primitives: start, address byte, data pages, stop.

Top module: `ddc_page_master`

## Requirements
- R1: After reset, the word at offset 0x0 reads 0x0120000C (divider 288, both sensed lines high, every control bit 0). The word at offset 0x4 reads 0, and both data words read 0.
- R2: Offset 0x0 holds these fields: bit 31 open-drain select, bits 27:16 divider, bit 1 master enable, bit 0 stretch enable; bits 3 (clock line) and 2 (data line) are read-only sensed levels. Offset 0x4 holds these fields: bits 23:16 acknowledge vector (read-only), bits 10:8 page length minus one, bits 6:4 mode, bit 0 trigger. Writing 1 to the trigger starts a primitive only if the master enable is 1 and the mode is 1 (start), 2 (write), 3 (stop), 4 (read, last byte unacknowledged) or 5 (read, all acknowledged). Any other write leaves the trigger at 0.
- R3: A start primitive lowers the data line while the clock line is high, and it ends with both lines held low.
- R4: A write primitive sends page-length-plus-one bytes. Byte i is bits 8i+7:8i of the 64-bit value {word 0xC, word 0x8}, sent most significant bit first. Each byte takes 9 clock pulses, and acknowledge-vector bit i is 1 exactly when the data line was low in byte i's ninth pulse.
- R5: A read primitive stores received byte i at the same bit position as in R4 and leaves the bytes beyond the page unchanged. In mode 5 the master pulls the data line low in every acknowledge slot. In mode 4 it does so in every slot except the last. The acknowledge vector therefore reads (1<<n)-1 in mode 5 and (1<<(n-1))-1 in mode 4, where n is the byte count.
- R6: A stop primitive raises the data line while the clock line is high, and it ends with both lines released high.
- R7: Within a page, the clock line has a period of 4 × max(divider, 2) system clocks.
- R8: During write and read primitives, the data line changes only while the clock line is low.
- R9: With stretch enable at 1, the high phase of the clock line does not advance while the sensed clock line is low, so a target that holds the clock low lengthens the period and the data is still transferred intact.
- R10: The trigger reads 1 from the cycle after an accepted trigger write until the primitive ends. While it reads 1, writes to the mode and page-length fields and to the data words are ignored.
- R11: The acknowledge vector reads 0 at the start of every primitive, so it reads 0 after a start or a stop.
- R12: With open-drain select at 1, each line output is 0 and its enable is 1 only when the line is pulled low. With open-drain select at 0, both enables are 1 and each output carries the line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte offset of the register word (bits 3:2 used) |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |
| scl_o | output | 1 | Clock line output value |
| scl_oe | output | 1 | Clock line output enable |
| scl_i | input | 1 | Sensed clock line |
| sda_o | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output enable |
| sda_i | input | 1 | Sensed data line |

## Verification
The assertions take the following for granted:
- the sensed lines come from a wired-AND bus on which the target changes the data line only after a falling clock edge;
- the target has released the data line before a start or a stop is issued;
- register writes arrive as single-cycle strobes.

The bench's target model changes its data drive only on falling clock edges, and it enters an idle state after a not-acknowledged read byte. The bench also forces the model's release before every start and stop. The divider stays at 2 or 3 (or 0, which the block clamps), so the two-cycle input synchronizer always settles before the sampling point.

// File: rtl/ddc_page_master.sv
module ddc_page_master #(
  parameter int DIV_W = 12,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(288)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        scl_o,
  output logic        scl_oe,
  input  logic        scl_i,
  output logic        sda_o,
  output logic        sda_oe,
  input  logic        sda_i
);
  localparam logic [2:0] M_START = 3'd1, M_WR = 3'd2, M_STOP = 3'd3, M_RDN = 3'd4, M_RDA = 3'd5;

  logic od_sel, stretch_en, m_en;
  logic [DIV_W-1:0] div;
  logic busy;
  logic [2:0] mode, plen;
  logic [7:0] ackv;
  logic [63:0] dat;
  logic [1:0] scl_sy, sda_sy;
  logic [DIV_W-1:0] tick;
  logic [1:0] q;
  logic [3:0] bit_i;
  logic [2:0] byte_i;
  logic [7:0] rx;
  logic hold_scl, hold_sda;
  logic scl_b, sda_b;

  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];
  wire [DIV_W-1:0] div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
  wire rd_mode = (mode == M_RDN) || (mode == M_RDA);
  wire byte_mode = rd_mode || (mode == M_WR);
  wire stall = stretch_en && (q == 2'd1 || q == 2'd2) && !scl_s;
  wire q_end = busy && !stall && (tick == div_eff - DIV_W'(1));
  wire last_slot = !byte_mode || (bit_i == 4'd8 && byte_i == plen);
  wire done = q_end && (q == 2'd3) && last_slot;
  wire [7:0] cur_tx = dat[{byte_i, 3'b000} +: 8];
  wire tx_bit = cur_tx[3'd7 - bit_i[2:0]];
  wire wr_c0 = wr_en && addr[3:2] == 2'd0;
  wire wr_c1 = wr_en && addr[3:2] == 2'd1;
  wire wr_d0 = wr_en && addr[3:2] == 2'd2;
  wire wr_d1 = wr_en && addr[3:2] == 2'd3;
  wire mode_ok = wdata[6:4] >= M_START && wdata[6:4] <= M_RDA;
  wire trig_ok = wr_c1 && wdata[0] && !busy && m_en && mode_ok;
  wire sample = q_end && q == 2'd1 && byte_mode;

  always_comb begin
    scl_b = 1'b1;
    sda_b = 1'b1;
    case (mode)
      M_START: begin
        scl_b = q[0] ^ q[1];
        sda_b = !q[1];
      end
      M_STOP: begin
        scl_b = q != 2'd0;
        sda_b = q[1];
      end
      default: begin
        scl_b = q[0] ^ q[1];
        if (bit_i == 4'd8) sda_b = rd_mode ? !(mode == M_RDA || byte_i != plen) : 1'b1;
        else sda_b = rd_mode ? 1'b1 : tx_bit;
      end
    endcase
  end

  wire scl_lvl = busy ? scl_b : hold_scl;
  wire sda_lvl = busy ? sda_b : hold_sda;

  assign scl_oe = od_sel ? !scl_lvl : 1'b1;
  assign scl_o  = od_sel ? 1'b0 : scl_lvl;
  assign sda_oe = od_sel ? !sda_lvl : 1'b1;
  assign sda_o  = od_sel ? 1'b0 : sda_lvl;

  always_comb begin
    case (addr[3:2])
      2'd0: rdata = {od_sel, 3'b000, 12'(div), 12'h000, scl_s, sda_s, m_en, stretch_en};
      2'd1: rdata = {8'h00, ackv, 5'b00000, plen, 1'b0, mode, 3'b000, busy};
      2'd2: rdata = dat[31:0];
      default: rdata = dat[63:32];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_sel <= 1'b0;
      stretch_en <= 1'b0;
      m_en <= 1'b0;
      div <= DIV_RST;
    end else if (wr_c0) begin
      od_sel <= wdata[31];
      div <= DIV_W'(wdata[27:16]);
      m_en <= wdata[1];
      stretch_en <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      mode <= 3'd0;
      plen <= 3'd0;
      tick <= '0;
      q <= 2'd0;
      bit_i <= 4'd0;
      byte_i <= 3'd0;
      hold_scl <= 1'b1;
      hold_sda <= 1'b1;
    end else if (!busy) begin
      if (wr_c1) begin
        mode <= wdata[6:4];
        plen <= wdata[10:8];
      end
      if (trig_ok) begin
        busy <= 1'b1;
        tick <= '0;
        q <= 2'd0;
        bit_i <= 4'd0;
        byte_i <= 3'd0;
      end
    end else if (q_end) begin
      tick <= '0;
      q <= q + 2'd1;
      if (done) begin
        busy <= 1'b0;
        hold_scl <= scl_b;
        hold_sda <= sda_b;
      end else if (q == 2'd3 && byte_mode) begin
        if (bit_i == 4'd8) begin
          bit_i <= 4'd0;
          byte_i <= byte_i + 3'd1;
        end else begin
          bit_i <= bit_i + 4'd1;
        end
      end
    end else if (!stall) begin
      tick <= tick + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat <= 64'd0;
      ackv <= 8'd0;
      rx <= 8'd0;
    end else if (!busy) begin
      if (wr_d0) dat[31:0] <= wdata;
      if (wr_d1) dat[63:32] <= wdata;
      if (trig_ok) ackv <= 8'd0;
    end else if (sample) begin
      if (bit_i == 4'd8) begin
        ackv[byte_i] <= !sda_s;
      end else begin
        rx <= {rx[6:0], sda_s};
        if (bit_i == 4'd7 && rd_mode) dat[{byte_i, 3'b000} +: 8] <= {rx[6:0], sda_s};
      end
    end
  end
endmodule

module ddc_page_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       m_en,
  input logic       stretch_en,
  input logic [2:0] mode,
  input logic [2:0] plen,
  input logic [7:0] ackv,
  input logic [1:0] q,
  input logic       scl_s,
  input logic       scl_lvl,
  input logic       sda_lvl,
  input logic       wr_en,
  input logic [3:0] addr
);
  // R2
  trig_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !m_en) |=> !busy);
  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ackv == 8'd0);
  // R8
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mode == 3'd2 || mode == 3'd4 || mode == 3'd5) && scl_lvl && $past(scl_lvl))
      |-> $stable(sda_lvl));
  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stretch_en && (q == 2'd1 || q == 2'd2) && !scl_s) |=> $stable(q));
  // R10
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr[3:2] == 2'd1) |=> ($stable(mode) && $stable(plen)));
  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mode == 3'd3) |-> (scl_lvl && sda_lvl));
  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mode == 3'd1) |-> (!scl_lvl && !sda_lvl));
endmodule

bind ddc_page_master ddc_page_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .m_en(m_en), .stretch_en(stretch_en),
  .mode(mode), .plen(plen), .ackv(ackv), .q(q), .scl_s(scl_s),
  .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .wr_en(wr_en), .addr(addr)
);

// File: tb/test_ddc_page_master.sv
module test_ddc_page_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic wr_en = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  wire [31:0] rdata;
  wire scl_o, scl_oe, sda_o, sda_oe;
  logic s_scl_hold = 1'b0, s_sda_hold = 1'b0;
  wire m_scl = scl_oe ? scl_o : 1'b1;
  wire m_sda = sda_oe ? sda_o : 1'b1;
  wire scl_line = m_scl & ~s_scl_hold;
  wire sda_line = m_sda & ~s_sda_hold;

  ddc_page_master i_ddc_page_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .scl_o(scl_o), .scl_oe(scl_oe), .scl_i(scl_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  int total = 0, bad = 0, cyc = 0;
  logic fin = 1'b0;
  always @(posedge clk) cyc++;

  // target model
  int s_bit = 0, s_byte = 0, s_stretch = 0;
  int s_rises = 0, s_stops = 0, s_starts = 0, s_gap = 0, s_last = 0, sda_hi_chg = 0;
  logic s_idle = 1'b1, s_rd = 1'b0, in_page = 1'b0;
  logic [7:0] s_sh = 8'd0, s_ackm = 8'd0;
  logic [7:0] s_rx [8];
  logic [7:0] s_tx [8];

  always @(negedge sda_line) if (scl_line) begin
    s_starts++; s_bit = 0; s_byte = 0; s_idle = 1'b0; s_sda_hold = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) s_stops++;
  always @(sda_line) if (scl_line && in_page) sda_hi_chg++;
  always @(posedge scl_line) begin
    s_rises++; s_gap = cyc - s_last; s_last = cyc;
    if (!s_idle) begin
      if (s_bit < 8) begin
        s_sh = {s_sh[6:0], sda_line};
        if (s_bit == 7) s_rx[s_byte % 8] = s_sh;
        s_bit++;
      end else begin
        if (s_rd && sda_line) s_idle = 1'b1;
        s_bit = 0; s_byte++;
      end
    end
  end
  always @(negedge scl_line) begin
    if (s_idle) s_sda_hold = 1'b0;
    else if (!s_rd) s_sda_hold = (s_bit == 8) && s_ackm[s_byte % 8];
    else s_sda_hold = (s_bit < 8) && !s_tx[s_byte % 8][7 - s_bit];
  end
  always @(negedge scl_line) if (s_stretch > 0) begin
    s_scl_hold = 1'b1;
    repeat (s_stretch) @(posedge clk);
    s_scl_hold = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(4'h4, v);
      if (!v[0]) return;
    end
    chk("R10 trigger never cleared", 32'd1, 32'd0);
  endtask

  task automatic run(input int m, input int pl);
    wr(4'h4, 32'((pl << 8) | (m << 4) | 1));
    wait_done();
  endtask

  task automatic release_target();
    s_idle = 1'b1; s_sda_hold = 1'b0;
  endtask

  function automatic logic [31:0] ctl0(input int dv, input logic st);
    return {1'b1, 3'b000, 12'(dv), 12'h000, 2'b00, 1'b1, st};
  endfunction

  task automatic summary();
    fin = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [31:0] v, d0, d1, p0, p1, ex0, ex1;
    logic [63:0] pat, exd;
    logic [7:0] mask;
    int r0, st0;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    rd(4'h0, v); chk("R1 ctl0 reset", v, 32'h0120000C);
    rd(4'h4, v); chk("R1 ctl1 reset", v, 32'h0);
    rd(4'h8, v); chk("R1 data0 reset", v, 32'h0);
    rd(4'hC, v); chk("R1 data1 reset", v, 32'h0);
    chk("R12 push-pull idle", {30'd0, scl_oe & scl_o, sda_oe & sda_o}, 32'h3);

    wr(4'h4, 32'h11);
    rd(4'h4, v); chk("R2 trigger ignored when disabled", {31'd0, v[0]}, 32'h0);
    wr(4'h0, 32'h8ABC_0003);
    rd(4'h0, v); chk("R2 ctl0 readback", v, 32'h8ABC000F);
    wr(4'h0, ctl0(2, 1'b0));
    wr(4'h4, 32'h61);
    rd(4'h4, v); chk("R2 invalid mode ignored", {31'd0, v[0]}, 32'h0);
    chk("R12 open-drain released", {30'd0, scl_oe, sda_oe}, 32'h0);

    release_target(); st0 = s_starts;
    run(1, 0);
    rd(4'h0, v); chk("R3 lines low after start", {30'd0, v[3:2]}, 32'h0);
    chk("R3 start seen", 32'(s_starts - st0), 32'd1);
    chk("R12 open-drain pulling low", {30'd0, scl_oe, sda_oe}, 32'h3);

    // write sweep
    for (int n = 1; n <= 8; n++) begin
      for (int k = 0; k < 3; k++) begin
        mask = (k == 0) ? 8'hFF : (8'hA5 ^ 8'(n * 37) ^ 8'(k * 91));
        for (int j = 0; j < 8; j++) pat[j*8 +: 8] = 8'(n * 17 + j * 29 + k * 7);
        wr(4'h8, pat[31:0]); wr(4'hC, pat[63:32]);
        release_target(); s_rd = 1'b0; s_ackm = mask;
        run(1, 0);
        in_page = 1'b1; r0 = s_rises;
        run(2, n - 1);
        in_page = 1'b0;
        rd(4'h4, v);
        chk($sformatf("R4 ack vector n=%0d", n), {24'd0, v[23:16]}, {24'd0, mask & 8'((1 << n) - 1)});
        chk($sformatf("R4 pulse count n=%0d", n), 32'(s_rises - r0), 32'(9 * n));
        for (int j = 0; j < n; j++)
          chk($sformatf("R4 byte %0d of %0d", j, n), {24'd0, s_rx[j]}, {24'd0, pat[j*8 +: 8]});
        if (n >= 2) chk("R7 period div=2", 32'(s_gap), 32'd8);
      end
    end

    release_target(); run(1, 0);
    rd(4'h4, v); chk("R11 ack vector cleared by start", {24'd0, v[23:16]}, 32'h0);

    // read sweep
    p0 = 32'h3C5A_96E1; p1 = 32'h7B24_D80F;
    for (int n = 1; n <= 8; n++) begin
      for (int am = 0; am < 2; am++) begin
        wr(4'h8, p0); wr(4'hC, p1);
        for (int j = 0; j < 8; j++) s_tx[j] = 8'(n * 53 + j * 71 + am * 13);
        release_target(); s_rd = 1'b1;
        run(1, 0);
        in_page = 1'b1;
        run(am ? 5 : 4, n - 1);
        in_page = 1'b0;
        exd = {p1, p0};
        for (int j = 0; j < n; j++) exd[j*8 +: 8] = s_tx[j];
        ex0 = exd[31:0]; ex1 = exd[63:32];
        rd(4'h8, v); chk($sformatf("R5 data0 n=%0d mode=%0d", n, am ? 5 : 4), v, ex0);
        rd(4'hC, v); chk($sformatf("R5 data1 n=%0d mode=%0d", n, am ? 5 : 4), v, ex1);
        rd(4'h4, v);
        chk($sformatf("R5 ack vector n=%0d mode=%0d", n, am ? 5 : 4), {24'd0, v[23:16]},
            am ? 32'((1 << n) - 1) : 32'((1 << (n - 1)) - 1));
        release_target(); st0 = s_stops;
        run(3, 0);
        chk("R6 stop seen", 32'(s_stops - st0), 32'd1);
      end
    end
    rd(4'h0, v); chk("R6 lines high after stop", {30'd0, v[3:2]}, 32'h3);
    rd(4'h4, v); chk("R11 ack vector cleared by stop", {24'd0, v[23:16]}, 32'h0);
    chk("R12 open-drain idle released", {30'd0, scl_oe, sda_oe}, 32'h0);

    // divider
    s_rd = 1'b0; s_ackm = 8'hFF;
    wr(4'h0, ctl0(3, 1'b0));
    release_target(); run(1, 0); run(2, 1);
    chk("R7 period div=3", 32'(s_gap), 32'd12);
    wr(4'h0, ctl0(0, 1'b0));
    release_target(); run(1, 0); run(2, 1);
    chk("R7 period div=0 clamps to 2", 32'(s_gap), 32'd8);

    // stretching
    wr(4'h0, ctl0(2, 1'b1));
    for (int j = 0; j < 8; j++) s_tx[j] = 8'(8'hC3 + j * 41);
    wr(4'h8, 32'h0); wr(4'hC, 32'h0);
    release_target(); s_rd = 1'b1; s_stretch = 12;
    run(1, 0); run(5, 2);
    s_stretch = 0;
    chk("R9 stretched period", 32'(s_gap >= 12), 32'd1);
    rd(4'h8, v); chk("R9 data intact under stretch", v, {8'h00, s_tx[2], s_tx[1], s_tx[0]});
    release_target(); run(3, 0);
    wr(4'h0, ctl0(2, 1'b0));

    // busy lockout
    s_rd = 1'b0; s_ackm = 8'hFF;
    wr(4'h8, 32'h1122_3344);
    release_target(); run(1, 0);
    wr(4'h4, 32'h721);
    rd(4'h4, v); chk("R10 trigger reads busy", {31'd0, v[0]}, 32'h1);
    wr(4'h4, 32'h031);
    wr(4'h8, 32'hFFFF_FFFF);
    wait_done();
    rd(4'h4, v); chk("R10 mode and length kept", {21'd0, v[10:8], 1'b0, v[6:4], 4'd0}, 32'h720);
    rd(4'h8, v); chk("R10 data write ignored while busy", v, 32'h1122_3344);
    release_target(); run(3, 0);

    chk("R8 data steady while clock high", 32'(sda_hi_chg), 32'd0);
    summary();
  end
endmodule